// File: doc/BRIEF.md
# Doubleword Multiply-Add Execution Unit

This integer execution unit takes three 64-bit source values A, B and C together with a 6-bit function code. It forms the exact 128-bit value A×B+C and returns one 64-bit half of it as the destination value. The function code picks two things: whether the operands are read as two's-complement or unsigned, and whether the upper or lower half is returned. The unit produces no carry, overflow or condition flags.

A request is one clock cycle of `start_i` with the operands and the function code. The unit then holds `busy_o` while an iterative multiplier works through the multiplier operand a few bits per cycle. The magnitude product is then given its sign and passed to a 128-bit adder that extends the addend. A one-cycle `done_o` pulse marks the result, and the result stays on `result_o` until the next accepted request changes it. A function code the unit does not support is answered one cycle later with `done_o` and `illegal_o` together and a zero result.

Top module: `dmadd_unit`

## Requirements
- R1: Function code 48 (6'b110000) reads A, B and C as signed two's-complement values and returns bits 127:64 of A×B+C.
- R2: Function code 49 (6'b110001) reads A, B and C as unsigned values and returns bits 127:64 of A×B+C.
- R3: Function code 51 (6'b110011) returns bits 63:0 of A×B+C, computed with signed operands.
- R4: The sum is exact to 128 bits, so a carry out of the low half caused by adding C reaches the returned high half.
- R5: In signed mode C is sign-extended to 128 bits before the addition, so a negative addend borrows from the high half. In unsigned mode C is zero-extended.
- R6: Any other function code raises `done_o` and `illegal_o` together for exactly one cycle, in the cycle after the start edge, with `result_o` at zero.
- R7: For a supported code, `busy_o` is high from the cycle after the start edge until `done_o`. `done_o` is a one-cycle pulse that is never high together with `busy_o`. It arrives no later than W/DIGIT+3 cycles after the start edge, which is 19 cycles with the default parameters.
- R8: `result_o` changes only in a cycle where `done_o` is high. Otherwise it holds its value, including across idle cycles.
- R9: A `start_i` pulse that arrives while `busy_o` is high is ignored. It does not change the result of the operation in flight and does not produce a second `done_o`.
- R10: While reset is held and after it is released, `busy_o`, `done_o` and `illegal_o` are low and `result_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request strobe |
| func_i | input | 6 | Function code (48, 49, 51 supported) |
| a_i | input | 64 | Multiplicand A |
| b_i | input | 64 | Multiplier B |
| c_i | input | 64 | Addend C |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| illegal_o | output | 1 | Unsupported function code, with done |
| result_o | output | 64 | Selected half of the 128-bit result |

## Verification
A wrong step count or a digit that is dropped in the iterative multiplier changes the product at once. It shows up as a wrong high or low half on the first `done_o` of an operation that uses the corrupted digit. A wrong sign flag or a wrong addend extension is hidden for small positive operands. It appears only with the most negative operand, with all-ones unsigned operands or with a negative addend that borrows, so those values are driven directly. Handshake faults, such as a second done, a busy that stays high or a start accepted while busy, show up within the 19-cycle operation window as an extra or missing pulse, or as a result that belongs to the wrong request.

// File: rtl/dmadd_pkg.sv
package dmadd_pkg;

    localparam int unsigned FUNC_W = 6;

    localparam logic [FUNC_W-1:0] FN_HIGH_SIGNED   = 6'd48;
    localparam logic [FUNC_W-1:0] FN_HIGH_UNSIGNED = 6'd49;
    localparam logic [FUNC_W-1:0] FN_LOW           = 6'd51;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_MUL,
        ST_ADD
    } top_state_e;

    typedef enum logic [1:0] {
        MS_IDLE,
        MS_RUN,
        MS_SIGN
    } mul_state_e;

    typedef struct packed {
        logic legal;
        logic is_signed;
        logic want_high;
    } op_ctrl_t;

endpackage

// File: rtl/dmadd_decode.sv
module dmadd_decode
    import dmadd_pkg::*;
(
    input  logic [FUNC_W-1:0] func_i,
    output op_ctrl_t          ctrl_o
);

    always_comb begin
        ctrl_o = '0;
        unique case (func_i)
            FN_HIGH_SIGNED: begin
                ctrl_o.legal     = 1'b1;
                ctrl_o.is_signed = 1'b1;
                ctrl_o.want_high = 1'b1;
            end
            FN_HIGH_UNSIGNED: begin
                ctrl_o.legal     = 1'b1;
                ctrl_o.is_signed = 1'b0;
                ctrl_o.want_high = 1'b1;
            end
            FN_LOW: begin
                // low half is identical for both readings; signed is used
                ctrl_o.legal     = 1'b1;
                ctrl_o.is_signed = 1'b1;
                ctrl_o.want_high = 1'b0;
            end
            default: ctrl_o = '0;
        endcase
    end

endmodule

// File: rtl/dmadd_mul_seq.sv
module dmadd_mul_seq
    import dmadd_pkg::*;
#(
    parameter int unsigned W     = 64,
    parameter int unsigned DIGIT = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic           signed_i,
    input  logic [W-1:0]   a_i,
    input  logic [W-1:0]   b_i,
    output logic           done_o,
    output logic [2*W-1:0] product_o
);

    localparam int unsigned STEPS = W / DIGIT;
    localparam int unsigned CNT_W = $clog2(STEPS + 1);
    localparam int unsigned UP_W  = W + DIGIT;

    typedef struct packed {
        mul_state_e     state;
        logic [CNT_W-1:0] cnt;
        logic [W-1:0]   mcand;
        logic [2*W-1:0] acc;
        logic           neg;
        logic [2*W-1:0] product;
        logic           done;
    } mul_regs_t;

    mul_regs_t r_d, r_q;

    logic [W-1:0]    mag_a, mag_b;
    logic [DIGIT-1:0] digit;
    logic [UP_W-1:0] partial;
    logic [UP_W-1:0] upper;
    logic [2*W-1:0]  step_acc;

    // magnitudes of the operands (unsigned reading of -MIN is exact)
    always_comb begin
        mag_a = (signed_i && a_i[W-1]) ? (~a_i + 1'b1) : a_i;
        mag_b = (signed_i && b_i[W-1]) ? (~b_i + 1'b1) : b_i;
    end

    // one radix-2^DIGIT step: add mcand*digit into the top, shift right
    always_comb begin
        digit   = r_q.acc[DIGIT-1:0];
        partial = '0;
        for (int j = 0; j < DIGIT; j++) begin
            if (digit[j]) begin
                partial = partial + ({{DIGIT{1'b0}}, r_q.mcand} << j);
            end
        end
        upper    = {{DIGIT{1'b0}}, r_q.acc[2*W-1:W]} + partial;
        step_acc = {upper, r_q.acc[W-1:DIGIT]};
    end

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.state)
            MS_IDLE: begin
                if (start_i) begin
                    r_d.mcand = mag_a;
                    r_d.acc   = {{W{1'b0}}, mag_b};
                    r_d.neg   = signed_i & (a_i[W-1] ^ b_i[W-1]);
                    r_d.cnt   = '0;
                    r_d.state = MS_RUN;
                end
            end
            MS_RUN: begin
                r_d.acc = step_acc;
                r_d.cnt = r_q.cnt + 1'b1;
                if (r_q.cnt == CNT_W'(STEPS - 1)) begin
                    r_d.state = MS_SIGN;
                end
            end
            MS_SIGN: begin
                r_d.product = r_q.neg ? (~r_q.acc + 1'b1) : r_q.acc;
                r_d.done    = 1'b1;
                r_d.state   = MS_IDLE;
            end
            default: r_d.state = MS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: MS_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign done_o    = r_q.done;
    assign product_o = r_q.product;

    // every digit of the multiplier must be visited: the step count stays in range (R4)
    p_step_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == MS_RUN) |-> (r_q.cnt < CNT_W'(STEPS)));

    // a finished multiply is reported once (R7)
    p_mul_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // the sign step always follows the final iteration (R4)
    p_sign_after_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == MS_SIGN) |-> ($past(r_q.state) == MS_RUN));

endmodule

// File: rtl/dmadd_add_wide.sv
module dmadd_add_wide #(
    parameter int unsigned W = 64
) (
    input  logic [2*W-1:0] prod_i,
    input  logic [W-1:0]   addend_i,
    input  logic           signed_i,
    output logic [2*W-1:0] sum_o
);

    logic [W:0]   low_sum;
    logic [W-1:0] ext_hi;
    logic [W-1:0] high_sum;

    // two limbs with an explicit carry between them
    always_comb begin
        low_sum  = {1'b0, prod_i[W-1:0]} + {1'b0, addend_i};
        ext_hi   = (signed_i && addend_i[W-1]) ? {W{1'b1}} : {W{1'b0}};
        high_sum = prod_i[2*W-1:W] + ext_hi + {{(W-1){1'b0}}, low_sum[W]};
        sum_o    = {high_sum, low_sum[W-1:0]};
    end

endmodule

// File: rtl/dmadd_unit.sv
module dmadd_unit
    import dmadd_pkg::*;
#(
    parameter int unsigned W     = 64,
    parameter int unsigned DIGIT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [FUNC_W-1:0] func_i,
    input  logic [W-1:0]      a_i,
    input  logic [W-1:0]      b_i,
    input  logic [W-1:0]      c_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              illegal_o,
    output logic [W-1:0]      result_o
);

    typedef struct packed {
        top_state_e     state;
        logic           is_signed;
        logic           want_high;
        logic [W-1:0]   addend;
        logic [2*W-1:0] prod;
        logic [W-1:0]   result;
        logic           done;
        logic           illegal;
    } top_regs_t;

    top_regs_t r_d, r_q;

    op_ctrl_t       ctrl;
    logic           mul_start;
    logic           mul_done;
    logic [2*W-1:0] mul_product;
    logic [2*W-1:0] sum;

    dmadd_decode i_decode (
        .func_i (func_i),
        .ctrl_o (ctrl)
    );

    dmadd_mul_seq #(
        .W     (W),
        .DIGIT (DIGIT)
    ) i_mul (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (mul_start),
        .signed_i  (ctrl.is_signed),
        .a_i       (a_i),
        .b_i       (b_i),
        .done_o    (mul_done),
        .product_o (mul_product)
    );

    dmadd_add_wide #(
        .W (W)
    ) i_add (
        .prod_i   (r_q.prod),
        .addend_i (r_q.addend),
        .signed_i (r_q.is_signed),
        .sum_o    (sum)
    );

    always_comb begin
        r_d         = r_q;
        r_d.done    = 1'b0;
        r_d.illegal = 1'b0;
        mul_start   = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    if (!ctrl.legal) begin
                        r_d.result  = '0;
                        r_d.done    = 1'b1;
                        r_d.illegal = 1'b1;
                    end else begin
                        mul_start     = 1'b1;
                        r_d.is_signed = ctrl.is_signed;
                        r_d.want_high = ctrl.want_high;
                        r_d.addend    = c_i;
                        r_d.state     = ST_MUL;
                    end
                end
            end
            ST_MUL: begin
                if (mul_done) begin
                    r_d.prod  = mul_product;
                    r_d.state = ST_ADD;
                end
            end
            ST_ADD: begin
                r_d.result = r_q.want_high ? sum[2*W-1:W] : sum[W-1:0];
                r_d.done   = 1'b1;
                r_d.state  = ST_IDLE;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o    = (r_q.state != ST_IDLE);
    assign done_o    = r_q.done;
    assign illegal_o = r_q.illegal;
    assign result_o  = r_q.result;

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_done_not_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    p_illegal_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (done_o && (result_o == '0)));

    p_result_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (done_o || $stable(result_o)));

    p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> (busy_o || (done_o && !illegal_o)));

    p_mul_only_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mul_done |-> busy_o);

endmodule

// File: tb/test_dmadd_unit.sv
module test_dmadd_unit;

    logic        clk;
    logic        rst_n;
    logic        start_i;
    logic [5:0]  func_i;
    logic [63:0] a_i, b_i, c_i;
    logic        busy_o, done_o, illegal_o;
    logic [63:0] result_o;

    int n_checks = 0;
    int n_fail   = 0;

    localparam int MAX_LAT = 64 / 4 + 3;

    dmadd_unit i_dmadd_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .func_i    (func_i),
        .a_i       (a_i),
        .b_i       (b_i),
        .c_i       (c_i),
        .busy_o    (busy_o),
        .done_o    (done_o),
        .illegal_o (illegal_o),
        .result_o  (result_o)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] ref_model(input logic [5:0] f, input logic [63:0] a,
                                              input logic [63:0] b, input logic [63:0] c);
        logic [127:0] ea, eb, ec, full;
        bit sgn;
        sgn  = (f != 6'd49);
        ea   = sgn ? {{64{a[63]}}, a} : {64'd0, a};
        eb   = sgn ? {{64{b[63]}}, b} : {64'd0, b};
        ec   = sgn ? {{64{c[63]}}, c} : {64'd0, c};
        full = ea * eb + ec;
        return (f == 6'd51) ? full[63:0] : full[127:64];
    endfunction

    // issue one legal operation and check handshake, latency and value
    task automatic run_op(input logic [5:0] f, input logic [63:0] a, input logic [63:0] b,
                          input logic [63:0] c, input string req);
        int n;
        logic [63:0] exp;
        exp = ref_model(f, a, b, c);
        @(negedge clk);
        start_i = 1'b1; func_i = f; a_i = a; b_i = b; c_i = c;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o === 1'b1, "R7 busy after start", {63'd0, busy_o}, 64'd1);
        n = 0;
        while (done_o !== 1'b1 && n < 100) begin
            @(negedge clk);
            n++;
        end
        check(n <= MAX_LAT, "R7 latency", 64'(n), 64'(MAX_LAT));
        check(busy_o === 1'b0 && illegal_o === 1'b0, "R7 done without busy/illegal",
              {62'd0, busy_o, illegal_o}, 64'd0);
        check(result_o === exp, req, result_o, exp);
        @(negedge clk);
        check(done_o === 1'b0, "R7 done pulse", {63'd0, done_o}, 64'd0);
    endtask

    task automatic t_reset;
        check(busy_o === 1'b0 && done_o === 1'b0 && illegal_o === 1'b0,
              "R10 reset flags", {61'd0, busy_o, done_o, illegal_o}, 64'd0);
        check(result_o === 64'd0, "R10 reset result", result_o, 64'd0);
    endtask

    task automatic t_signed_high;
        run_op(6'd48, 64'd3, 64'd5, 64'd7, "R1 small positive");
        run_op(6'd48, -64'sd3, 64'd5, 64'd7, "R1 negative product");
        run_op(6'd48, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 64'd0,
               "R1 most-negative squared");
        run_op(6'd48, 64'h7FFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000, 64'h1234,
               "R1 max times min");
    endtask

    task automatic t_unsigned_high;
        run_op(6'd49, '1, '1, '1, "R2 all ones");
        run_op(6'd49, 64'h8000_0000_0000_0000, 64'd2, 64'd0, "R2 top bit unsigned");
        run_op(6'd49, 64'hDEAD_BEEF_0123_4567, 64'hFEDC_BA98_7654_3210, 64'h5555, "R2 mixed");
    endtask

    task automatic t_low;
        run_op(6'd51, 64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321, 64'h1111, "R3 low half");
        run_op(6'd51, '1, '1, '1, "R3 low all ones");
        run_op(6'd51, -64'sd9, 64'd7, -64'sd1, "R3 low negative");
    endtask

    task automatic t_carry;
        run_op(6'd49, '1, 64'd1, 64'd1, "R4 carry into high unsigned");
        run_op(6'd48, 64'h0000_0000_FFFF_FFFF, 64'h0000_0001_0000_0001, 64'd1,
               "R4 carry into high signed");
    endtask

    task automatic t_extend;
        run_op(6'd48, 64'd1, 64'd1, -64'sd2, "R5 signed borrow");
        run_op(6'd49, 64'd1, 64'd1, -64'sd2, "R5 unsigned zero-extend");
        run_op(6'd48, 64'h1_0000_0000, 64'h1_0000_0000, -64'sd1, "R5 borrow from 2^64");
    endtask

    task automatic t_illegal(input logic [5:0] f);
        @(negedge clk);
        start_i = 1'b1; func_i = f; a_i = 64'd9; b_i = 64'd9; c_i = 64'd9;
        @(negedge clk);
        start_i = 1'b0;
        check(done_o === 1'b1 && illegal_o === 1'b1, "R6 illegal flags",
              {62'd0, done_o, illegal_o}, 64'd3);
        check(result_o === 64'd0, "R6 illegal result zero", result_o, 64'd0);
        @(negedge clk);
        check(done_o === 1'b0 && illegal_o === 1'b0 && busy_o === 1'b0, "R6 one cycle",
              {61'd0, done_o, illegal_o, busy_o}, 64'd0);
    endtask

    task automatic t_hold;
        logic [63:0] held;
        run_op(6'd49, 64'd1000, 64'd1000, 64'd1, "R8 setup");
        held = result_o;
        repeat (5) @(negedge clk);
        check(result_o === held, "R8 result held while idle", result_o, held);
    endtask

    task automatic t_busy_start;
        int n;
        logic [63:0] exp;
        int dones;
        exp = ref_model(6'd49, 64'd77, 64'd88, 64'd99);
        @(negedge clk);
        start_i = 1'b1; func_i = 6'd49; a_i = 64'd77; b_i = 64'd88; c_i = 64'd99;
        @(negedge clk);
        start_i = 1'b0;
        repeat (3) @(negedge clk);
        start_i = 1'b1; func_i = 6'd51; a_i = '1; b_i = '1; c_i = '1;
        @(negedge clk);
        start_i = 1'b0;
        n = 0;
        while (done_o !== 1'b1 && n < 100) begin
            @(negedge clk);
            n++;
        end
        check(result_o === exp, "R9 first request kept", result_o, exp);
        dones = 0;
        repeat (30) begin
            @(negedge clk);
            if (done_o === 1'b1) dones++;
        end
        check(dones == 0, "R9 no second done", 64'(dones), 64'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; start_i = 1'b0; func_i = '0; a_i = '0; b_i = '0; c_i = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_signed_high();
        t_unsigned_high();
        t_low();
        t_carry();
        t_extend();
        t_illegal(6'd50);
        t_illegal(6'd0);
        t_illegal(6'd63);
        t_hold();
        t_busy_start();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule